// File: doc/BRIEF.md
# Conditional Write Response Dispatcher

This block sits between the memory side of a write path and a set of five write clients. Each time a client issues a write request, the request side pushes one flag into that client's acknowledge queue, saying whether the client wants to hear about the write's completion. When memory later returns a write-completion response tagged with a client ID, the block pops one flag from that client's queue. It sends the client a single-cycle completion pulse only if the popped flag is set. A response whose flag is clear is absorbed without a pulse.

Each client has a 16-bit response counter that wraps. It counts every response the block takes for that client, whether or not a pulse went out. A response carrying an ID that names no client is taken and dropped, and it raises a one-cycle error pulse. The response input stalls, with ready held low, while the addressed client's queue is empty.

Top module: `wr_rsp_dispatch`

## Requirements
- R1: Response IDs 0 to 4 address clients 0 to 4. Bit c of every per-client vector, and bits c*16+15 down to c*16 of `rsp_cnt_o`, belong to client c.
- R2: A response is accepted when `rsp_valid_i` and `rsp_ready_o` are both high. Each accepted response with a client ID removes exactly one flag from that client's queue, and the queue hands flags out in the order they were pushed.
- R3: When the removed flag is 1, `done_o[id]` is high for exactly one cycle, in the cycle after acceptance. No other bit of `done_o` is high in that cycle.
- R4: When the removed flag is 0, no bit of `done_o` rises for that response, and the client's counter still advances.
- R5: Each accepted response with a client ID adds 1 to that client's counter, visible in the cycle after acceptance. The counter wraps from 65535 to 0.
- R6: For a client ID, `rsp_ready_o` is low while that client's queue is empty. A response presented in that state is not consumed and changes no counter.
- R7: For an ID of 5, 6 or 7, `rsp_ready_o` is high. Acceptance raises `err_o` for one cycle, in the cycle after acceptance. It removes no flag, changes no counter and raises no `done_o` bit.
- R8: Each queue holds 8 flags. `flag_ready_o[c]` is low while 8 are held, and a push into a full queue is ignored.
- R9: `cnt_clr_i` high at a clock edge sets every counter to 0 in the next cycle. It takes priority over an increment in the same cycle and leaves the queues untouched.
- R10: While `rst_ni` is low, the queues are empty, the counters read 0, `done_o` and `err_o` are low, and `flag_ready_o` is all ones.
- R11: A push and an accepted response on the same client in the same cycle both take effect.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_push_i | input | 5 | Per-client push strobe into the acknowledge queue |
| flag_val_i | input | 5 | Per-client flag value pushed (1 = acknowledge wanted) |
| flag_ready_o | output | 5 | Per-client queue not full |
| rsp_valid_i | input | 1 | Write response valid |
| rsp_id_i | input | 3 | Write response client ID |
| rsp_ready_o | output | 1 | Write response accepted this cycle if valid |
| cnt_clr_i | input | 1 | Synchronous clear of all response counters |
| done_o | output | 5 | Per-client one-cycle completion pulse |
| rsp_cnt_o | output | 80 | Per-client response counters, 16 bits each |
| err_o | output | 1 | One-cycle pulse for an accepted unknown ID |

## Verification
A push and a response pop can land on the same client queue in the same clock edge. The bench provokes this in two ways. It keeps a single-flag queue on client 2 alive for 65 536 consecutive responses, each paired with a push, which also drives that counter through its wrap. It also pairs a pop with a push against a full queue. A behavioural model built on queues judges both. After every edge it must match the block on pulse, counter, ready and fullness. The second overlap is a counter clear in the same edge as an accepted response, where the model expects zero and the pulse still present.

// File: rtl/wrd_pkg.sv
package wrd_pkg;
  localparam int unsigned WRD_CLIENTS = 5;
  localparam int unsigned WRD_ID_W    = 3;
  localparam int unsigned WRD_QDEPTH  = 8;
  localparam int unsigned WRD_CNT_W   = 16;

  function automatic int unsigned wrd_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wrd_flag_queue.sv
module wrd_flag_queue #(
  parameter int unsigned DEPTH = wrd_pkg::WRD_QDEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic flag_i,
  input  logic pop_i,
  output logic head_o,
  output logic empty_o,
  output logic full_o
);
  localparam int unsigned PTR_W = wrd_pkg::wrd_bits(DEPTH);
  localparam int unsigned OCC_W = wrd_pkg::wrd_bits(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [OCC_W-1:0] occ_q;
  logic push_ok, pop_ok;

  assign empty_o = (occ_q == '0);
  assign full_o  = (occ_q == OCC_W'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= flag_i;
        wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      end
      if (pop_ok) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R6
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o); // R8
endmodule

// File: rtl/wrd_counter.sv
module wrd_counter #(
  parameter int unsigned W = wrd_pkg::WRD_CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0)); // R9
endmodule

// File: rtl/wrd_id_decode.sv
module wrd_id_decode #(
  parameter int unsigned N    = wrd_pkg::WRD_CLIENTS,
  parameter int unsigned ID_W = wrd_pkg::WRD_ID_W
) (
  input  logic [ID_W-1:0] id_i,
  output logic [N-1:0]    sel_o,
  output logic            bad_o
);
  for (genvar c = 0; c < N; c++) begin : g_sel
    assign sel_o[c] = (id_i == ID_W'(c));
  end
  assign bad_o = ~|sel_o;

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(sel_o)); // R1
  end
endmodule

// File: rtl/wr_rsp_dispatch.sv
module wr_rsp_dispatch #(
  parameter int unsigned NUM_CLIENTS = wrd_pkg::WRD_CLIENTS,
  parameter int unsigned ID_W        = wrd_pkg::WRD_ID_W,
  parameter int unsigned QDEPTH      = wrd_pkg::WRD_QDEPTH,
  parameter int unsigned CNT_W       = wrd_pkg::WRD_CNT_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CLIENTS-1:0]       flag_push_i,
  input  logic [NUM_CLIENTS-1:0]       flag_val_i,
  output logic [NUM_CLIENTS-1:0]       flag_ready_o,
  input  logic                         rsp_valid_i,
  input  logic [ID_W-1:0]              rsp_id_i,
  output logic                         rsp_ready_o,
  input  logic                         cnt_clr_i,
  output logic [NUM_CLIENTS-1:0]       done_o,
  output logic [NUM_CLIENTS*CNT_W-1:0] rsp_cnt_o,
  output logic                         err_o
);
  logic [NUM_CLIENTS-1:0] sel, pop, head, empty, full;
  logic bad, accept;

  wrd_id_decode #(.N(NUM_CLIENTS), .ID_W(ID_W)) u_dec (
    .id_i (rsp_id_i),
    .sel_o(sel),
    .bad_o(bad)
  );

  assign rsp_ready_o  = bad || |(sel & ~empty);
  assign accept       = rsp_valid_i && rsp_ready_o;
  assign pop          = sel & {NUM_CLIENTS{accept}};
  assign flag_ready_o = ~full;

  for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client
    wrd_flag_queue #(.DEPTH(QDEPTH)) u_q (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (flag_push_i[c]),
      .flag_i (flag_val_i[c]),
      .pop_i  (pop[c]),
      .head_o (head[c]),
      .empty_o(empty[c]),
      .full_o (full[c])
    );
    wrd_counter #(.W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (cnt_clr_i),
      .inc_i (pop[c]),
      .cnt_o (rsp_cnt_o[c*CNT_W +: CNT_W])
    );
  end

  // pulse only when the popped flag asks for an acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= '0;
      err_o  <= 1'b0;
    end else begin
      done_o <= pop & head;
      err_o  <= accept && bad;
    end
  end

  AST_DONE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o)); // R3
  AST_DONE_HAS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |-> $past(rsp_valid_i && rsp_ready_o)); // R3
  AST_ERR_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o == '0)); // R7
  AST_READY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bad && ((sel & ~empty) == '0)) |-> !rsp_ready_o); // R6
endmodule

// File: tb/wr_rsp_dispatch_bench.sv
module wr_rsp_dispatch_bench;
  localparam int NC = 5;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] push = '0, val = '0;
  logic [NC-1:0] flag_ready, done;
  logic rv = 1'b0, ready, err, clr = 1'b0;
  logic [2:0] id = '0;
  logic [NC*CW-1:0] cnt;

  always #5 clk = ~clk;

  wr_rsp_dispatch u_wr_rsp_dispatch (
    .clk_i(clk), .rst_ni(rst_n),
    .flag_push_i(push), .flag_val_i(val), .flag_ready_o(flag_ready),
    .rsp_valid_i(rv), .rsp_id_i(id), .rsp_ready_o(ready),
    .cnt_clr_i(clr), .done_o(done), .rsp_cnt_o(cnt), .err_o(err)
  );

  // behavioural reference
  bit m_q[NC][$];
  int m_cnt[NC];
  logic [NC-1:0] m_done;
  logic m_err;
  int n_vec = 0, n_bad = 0, cycles = 0;
  string phase = "R10";

  function automatic logic m_ready();
    if (id >= NC) return 1'b1;
    return m_q[id].size() > 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin m_q[c].delete(); m_cnt[c] = 0; end
      m_done = '0;
      m_err = 1'b0;
    end else begin
      bit full_b[NC];
      logic acc;
      for (int c = 0; c < NC; c++) full_b[c] = (m_q[c].size() >= 8);
      acc = rv && m_ready();
      m_done = '0;
      m_err = 1'b0;
      if (clr) for (int c = 0; c < NC; c++) m_cnt[c] = 0;
      if (acc) begin
        if (id < NC) begin
          m_done[id] = m_q[id].pop_front();
          if (!clr) m_cnt[id] = (m_cnt[id] + 1) % 65536;
        end else m_err = 1'b1;
      end
      for (int c = 0; c < NC; c++)
        if (push[c] && !full_b[c]) m_q[c].push_back(val[c]);
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  task automatic check_regs();
    logic [NC-1:0] efr;
    chk("done_o", done, m_done);
    chk("err_o", err, m_err);
    for (int c = 0; c < NC; c++) begin
      chk($sformatf("cnt[%0d]", c), cnt[c*CW +: CW], m_cnt[c]);
      efr[c] = (m_q[c].size() < 8);
    end
    chk("flag_ready_o", flag_ready, efr);
  endtask

  task automatic step(input logic [NC-1:0] p, input logic [NC-1:0] v,
                      input logic r, input logic [2:0] i, input logic cl);
    @(negedge clk);
    check_regs();
    push = p; val = v; rv = r; id = i; clr = cl;
    #1 chk("rsp_ready_o", ready, m_ready());
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step('0, '0, 1'b0, 3'd0, 1'b0);
  endtask

  initial begin
    while (cycles < 200000) begin @(posedge clk); cycles++; end
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("reset done_o", done, 0);
    chk("reset err_o", err, 0);
    chk("reset cnt", cnt, 0);
    chk("reset flag_ready_o", flag_ready, 5'h1f);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R3: two flags each client, fifo order 1 then 0 / 0 then 1
    phase = "R2";
    step(5'h1f, 5'b10101, 1'b0, 3'd0, 1'b0);
    step(5'h1f, 5'b01010, 1'b0, 3'd0, 1'b0);
    for (int c = 0; c < NC; c++) step('0, '0, 1'b1, 3'(c), 1'b0);
    phase = "R3";
    for (int c = NC - 1; c >= 0; c--) step('0, '0, 1'b1, 3'(c), 1'b0);
    idle(2);

    // R4 flag 0 absorbed, counter still counts
    phase = "R4";
    step(5'b00010, 5'b00000, 1'b0, 3'd0, 1'b0);
    step('0, '0, 1'b1, 3'd1, 1'b0);
    idle(2);

    // R6 empty queue stalls the response
    phase = "R6";
    for (int k = 0; k < 3; k++) step('0, '0, 1'b1, 3'd3, 1'b0);
    step(5'b01000, 5'b01000, 1'b1, 3'd3, 1'b0);
    step('0, '0, 1'b1, 3'd3, 1'b0);
    idle(2);

    // R7 unknown ids
    phase = "R7";
    step(5'b00001, 5'b00001, 1'b0, 3'd0, 1'b0);
    for (int i = 5; i < 8; i++) step('0, '0, 1'b1, 3'(i), 1'b0);
    idle(1);
    step('0, '0, 1'b1, 3'd0, 1'b0);
    idle(2);

    // R8 fill client 4, ninth push dropped, then drain
    phase = "R8";
    for (int k = 0; k < 9; k++) step(5'b10000, {k[0], 4'b0}, 1'b0, 3'd0, 1'b0);
    // R11 pop and push together against full queue
    phase = "R11";
    step(5'b10000, 5'b10000, 1'b1, 3'd4, 1'b0);
    step(5'b10000, 5'b10000, 1'b0, 3'd0, 1'b0);
    phase = "R8";
    for (int k = 0; k < 10; k++) step('0, '0, 1'b1, 3'd4, 1'b0);
    idle(2);

    // R9 clear alongside an accepted response
    phase = "R9";
    step(5'b00100, 5'b00100, 1'b0, 3'd0, 1'b0);
    step('0, '0, 1'b1, 3'd2, 1'b1);
    idle(2);

    // R11 R5: push and pop every cycle on client 2 through counter wrap
    phase = "R5";
    step(5'b00100, 5'b00100, 1'b0, 3'd0, 1'b0);
    for (int k = 0; k < 65540; k++)
      step(5'b00100, {2'b0, k[1], 2'b0}, 1'b1, 3'd2, 1'b0);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule